// File: doc/BRIEF.md
# Reconfigurable Cascaded Biquad Filter Bank

The block holds four second-order IIR sections in transposed direct form II. Each section has its own five signed fixed-point coefficients: three feed-forward terms (B0, B1, B2) and two feedback terms (A1, A2). The feedback terms are added into the state registers, not subtracted. The sections are shared among `NUM_PATHS` parallel signal paths, a build-time choice of 1, 2 or 4. A run-time cascade count sets how many sections are chained along each path, so the bank can be regrouped without rebuilding it.

A strobe presents one 16-bit signed sample per path. Each path's filtered sample appears a fixed number of clocks later, which is the cascade count, and all paths are aligned under one valid strobe. Software loads coefficients and the cascade count through a plain write port. A coefficient is addressed by path, stage and coefficient index.

Top module: `biq_bank`

## Requirements
- R1: After reset, `out_valid` and `cfg_err` are 0 and the cascade count is 1. Every section holds B0 = 65536 with all other coefficients at 0, and its states are zero.
- R2: For each valid input x, a section does the following:
  - It outputs y = round_sat(B0·x + s1).
  - It updates s1 to B1·x + A1·y + s2.
  - It updates s2 to B2·x + A2·y.
  - Coefficients are 18-bit two's complement with 16 fractional bits. The products and states are kept at full precision.
- R3: The function round_sat adds 2^15 and shifts right arithmetically by 16, which rounds half up. It then clamps the result to [-32768, 32767].
- R4: `out_valid` pulses exactly S clocks after `in_valid` is sampled, where S is the cascade count. This holds for back-to-back samples, and one strobe covers all paths.
- R5: Path p runs its sample through sections p·S to p·S+S-1 in turn. Path p's input lane is `in_data[16p+15:16p]` and its output lane is `out_data[16p+15:16p]`.
- R6: A write with `wr_addr[7]`=1 targets the cascade count, taken from `wr_data[2:0]`. The write is accepted when `wr_data[17:3]` is zero, the count is 1, 2 or 4, and count·NUM_PATHS ≤ 4. An accepted write does the following:
  - It sets S to the new count.
  - It clears `cfg_err`.
  - It zeroes every state register and drops any samples in flight.
- R7: A rejected cascade-count write keeps the previous S and leaves the states untouched. It sets `cfg_err` to 1.
- R8: A write with `wr_addr[7]`=0 loads `wr_data` into one coefficient of section p·S+s, where:
  - p is the path, `wr_addr[6:5]`;
  - s is the stage, `wr_addr[4:3]`;
  - the coefficient index is `wr_addr[2:0]`, with 0 for B0, 1 for B1, 2 for B2, 3 for A1 and 4 for A2.

  The write is ignored if p ≥ NUM_PATHS, s ≥ S, or the index is above 4.
- R9: With pass-through coefficients on every stage of a path, each output equals its input bit-exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | One sample per path is present on `in_data` |
| in_data | input | 16·NUM_PATHS | Signed input samples, path 0 in the low lane |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Bit 7 selects the cascade count; otherwise path, stage and coefficient index |
| wr_data | input | 18 | Coefficient value or cascade count |
| out_valid | output | 1 | Filtered samples are present on `out_data` |
| out_data | output | 16·NUM_PATHS | Signed filtered samples, path 0 in the low lane |
| cfg_err | output | 1 | The last cascade-count write was rejected |

## Verification
The latency property assumes that samples are given time to drain before an accepted cascade-count write. After such a write, or after reset, it waits four clocks before relating `out_valid` to the input history. The stimulus therefore issues count writes only after six idle cycles. Coefficient writes, by contrast, are mixed freely with randomly gapped or back-to-back samples. Feed-forward coefficients are drawn from the full open range of ±2. Feedback coefficients are kept within ±0.5, so that runs both saturate and stay in the linear range, and directed cases hit the rounding ties and both clamp limits.

// File: rtl/biq_pkg.sv
`timescale 1ns/1ps
// Shared widths, the coefficient record and the output rounding function
// for the biquad bank. Assumes 16-bit samples and Q2.16 coefficients.
package biq_pkg;
    localparam int SMP_W  = 16;
    localparam int COEF_W = 18;
    localparam int FRAC_W = 16;
    localparam int NSEC   = 4;
    localparam int NCOEF  = 5;
    localparam int CIDX_W = 3;
    localparam int CNT_W  = 3;
    localparam int ADDR_W = 8;
    localparam int PROD_W = SMP_W + COEF_W;
    localparam int ACC_W  = PROD_W + 4;

    localparam logic signed [COEF_W-1:0] UNITY  = COEF_W'(1 << FRAC_W);
    localparam logic signed [ACC_W-1:0]  HALF   = ACC_W'(1 << (FRAC_W - 1));
    localparam logic signed [ACC_W-1:0]  SAT_HI = ACC_W'((1 << (SMP_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0]  SAT_LO = ~SAT_HI;

    typedef struct packed {
        logic [COEF_W-1:0] b0;
        logic [COEF_W-1:0] b1;
        logic [COEF_W-1:0] b2;
        logic [COEF_W-1:0] a1;
        logic [COEF_W-1:0] a2;
    } coef_t;

    // Round half up to the sample grid, then clamp to the sample range.
    function automatic logic signed [SMP_W-1:0] round_sat(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] r;
        r = (v + HALF) >>> FRAC_W;
        if (r > SAT_HI)
            return SAT_HI[SMP_W-1:0];
        else if (r < SAT_LO)
            return SAT_LO[SMP_W-1:0];
        else
            return r[SMP_W-1:0];
    endfunction
endpackage

// File: rtl/biq_section.sv
`timescale 1ns/1ps
// One transposed direct form II biquad with its own coefficient set.
// Feedback terms are added to the states. The output is registered, so a
// section adds one clock of latency. Assumes clr takes priority over in_v.
module biq_section
    import biq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     cwe,
    input  logic [CIDX_W-1:0]        cidx,
    input  logic signed [COEF_W-1:0] cdata,
    input  logic                     in_v,
    input  logic signed [SMP_W-1:0]  in_x,
    output logic                     out_v,
    output logic signed [SMP_W-1:0]  out_y
);
    coef_t                    c;
    logic signed [ACC_W-1:0]  s1, s2;
    logic signed [PROD_W-1:0] p_b0, p_b1, p_b2, p_a1, p_a2;
    logic signed [ACC_W-1:0]  acc, s1_n, s2_n;
    logic signed [SMP_W-1:0]  y_new;

    // Full-precision products, rounded output and next-state sums.
    always_comb begin
        p_b0  = PROD_W'(in_x) * PROD_W'($signed(c.b0));
        p_b1  = PROD_W'(in_x) * PROD_W'($signed(c.b1));
        p_b2  = PROD_W'(in_x) * PROD_W'($signed(c.b2));
        acc   = ACC_W'(p_b0) + s1;
        y_new = round_sat(acc);
        p_a1  = PROD_W'(y_new) * PROD_W'($signed(c.a1));
        p_a2  = PROD_W'(y_new) * PROD_W'($signed(c.a2));
        s1_n  = ACC_W'(p_b1) + ACC_W'(p_a1) + s2;
        s2_n  = ACC_W'(p_b2) + ACC_W'(p_a2);
    end

    // Coefficient storage: pass-through at reset, one field per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c.b0 <= UNITY;
            c.b1 <= '0;
            c.b2 <= '0;
            c.a1 <= '0;
            c.a2 <= '0;
        end else if (cwe) begin
            case (cidx)
                3'd0:    c.b0 <= cdata;
                3'd1:    c.b1 <= cdata;
                3'd2:    c.b2 <= cdata;
                3'd3:    c.a1 <= cdata;
                3'd4:    c.a2 <= cdata;
                default: ;
            endcase
        end
    end

    // State and output registers, cleared by reset or regrouping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            s1    <= '0;
            s2    <= '0;
            out_v <= 1'b0;
            out_y <= '0;
        end else begin
            out_v <= in_v;
            if (in_v) begin
                out_y <= y_new;
                s1    <= s1_n;
                s2    <= s2_n;
            end
        end
    end
endmodule

// File: rtl/biq_ctrl.sv
`timescale 1ns/1ps
// Write-port decoder and cascade-count register. It accepts or rejects
// count writes and maps (path, stage, index) to a section write enable
// under the current grouping. Assumes NUM_PATHS is 1, 2 or 4.
module biq_ctrl
    import biq_pkg::*;
#(
    parameter int NUM_PATHS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [COEF_W-1:0] wr_data,
    output logic [CNT_W-1:0]  stages,
    output logic [1:0]        stage_sh,
    output logic              cfg_err,
    output logic              clr,
    output logic [NSEC-1:0]   sec_we
);
    logic             is_cnt, cnt_ok, coef_ok;
    logic [CNT_W-1:0] cnt_req;
    logic [1:0]       path, stg;
    logic [3:0]       sec;

    // Decode the address fields and judge a count request.
    always_comb begin
        is_cnt  = wr_en && wr_addr[ADDR_W-1];
        cnt_req = wr_data[CNT_W-1:0];
        cnt_ok  = (wr_data[COEF_W-1:CNT_W] == '0)
                  && (cnt_req == 3'd1 || cnt_req == 3'd2 || cnt_req == 3'd4)
                  && (int'(cnt_req) * NUM_PATHS <= NSEC);
        clr     = is_cnt && cnt_ok;
        case (stages)
            3'd4:    stage_sh = 2'd2;
            3'd2:    stage_sh = 2'd1;
            default: stage_sh = 2'd0;
        endcase
        path    = wr_addr[6:5];
        stg     = wr_addr[4:3];
        sec     = ({2'b00, path} << stage_sh) + {2'b00, stg};
        coef_ok = wr_en && !wr_addr[ADDR_W-1]
                  && (int'(path) < NUM_PATHS)
                  && ({1'b0, stg} < stages)
                  && (int'(wr_addr[2:0]) < NCOEF);
        for (int k = 0; k < NSEC; k++)
            sec_we[k] = coef_ok && (sec == 4'(k));
    end

    // Cascade count and the rejection flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stages  <= 3'd1;
            cfg_err <= 1'b0;
        end else if (is_cnt) begin
            if (cnt_ok) begin
                stages  <= cnt_req;
                cfg_err <= 1'b0;
            end else begin
                cfg_err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/biq_bank.sv
`timescale 1ns/1ps
// Bank of four biquads regrouped at run time into NUM_PATHS parallel
// paths of S cascaded sections each. Latency is S clocks, and all paths
// share one valid strobe. Sections beyond NUM_PATHS*S stay idle.
module biq_bank
    import biq_pkg::*;
#(
    parameter int NUM_PATHS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [NUM_PATHS*SMP_W-1:0] in_data,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [COEF_W-1:0]          wr_data,
    output logic                       out_valid,
    output logic [NUM_PATHS*SMP_W-1:0] out_data,
    output logic                       cfg_err
);
    logic [CNT_W-1:0]        stages;
    logic [1:0]              stage_sh;
    logic                    clr;
    logic [NSEC-1:0]         sec_we;
    logic [NSEC-1:0]         sec_v;
    logic signed [SMP_W-1:0] sec_y [NSEC];
    logic signed [SMP_W-1:0] lane  [NUM_PATHS];

    biq_ctrl #(.NUM_PATHS(NUM_PATHS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .stages   (stages),
        .stage_sh (stage_sh),
        .cfg_err  (cfg_err),
        .clr      (clr),
        .sec_we   (sec_we)
    );

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_lane
        assign lane[p] = in_data[p*SMP_W +: SMP_W];
    end

    for (genvar k = 0; k < NSEC; k++) begin : g_sec
        logic                    v_i;
        logic signed [SMP_W-1:0] x_i;
        if (k == 0) begin : g_head
            // Section 0 always heads path 0.
            always_comb begin
                v_i = in_valid;
                x_i = lane[0];
            end
        end else begin : g_link
            logic       first;
            logic [2:0] kp;
            // Heads a path when k is a multiple of S; otherwise chains on k-1.
            always_comb begin
                first = ((3'(k) & (stages - 3'd1)) == 3'd0);
                kp    = 3'(k) >> stage_sh;
                v_i   = 1'b0;
                x_i   = sec_y[k-1];
                if (first) begin
                    x_i = '0;
                    for (int p = 0; p < NUM_PATHS; p++) begin
                        if (kp == 3'(p)) begin
                            x_i = lane[p];
                            v_i = in_valid;
                        end
                    end
                end else begin
                    v_i = sec_v[k-1];
                end
            end
        end
        biq_section u_sec (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .cwe   (sec_we[k]),
            .cidx  (wr_addr[CIDX_W-1:0]),
            .cdata ($signed(wr_data)),
            .in_v  (v_i),
            .in_x  (x_i),
            .out_v (sec_v[k]),
            .out_y (sec_y[k])
        );
    end

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_out
        logic [3:0]              last;
        logic signed [SMP_W-1:0] y_sel;
        // Pick the last section of path p under the current grouping.
        always_comb begin
            last  = ({1'b0, 3'(p)} << stage_sh) + {1'b0, stages} - 4'd1;
            y_sel = '0;
            for (int k = 0; k < NSEC; k++)
                if (last == 4'(k)) y_sel = sec_y[k];
        end
        assign out_data[p*SMP_W +: SMP_W] = y_sel;
    end

    // Path 0's last section carries the common valid strobe.
    always_comb out_valid = sec_v[2'(stages - 3'd1)];
endmodule

// File: rtl/biq_bank_chk.sv
`timescale 1ns/1ps
// Property checker for biq_bank: reset state, latency against the input
// history, and accept/reject handling of cascade-count writes. Assumes
// samples drain before an accepted count write.
module biq_bank_chk
    import biq_pkg::*;
#(
    parameter int NUM_PATHS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              wr_en,
    input logic              cnt_sel,
    input logic [COEF_W-1:0] wr_data,
    input logic              out_valid,
    input logic              cfg_err,
    input logic [CNT_W-1:0]  stages
);
    logic       cnt_wr, good, was_rst;
    logic [3:0] vhist;
    logic [2:0] quiet;

    always_comb begin
        cnt_wr = wr_en && cnt_sel;
        good   = (wr_data[COEF_W-1:CNT_W] == '0)
                 && (wr_data[2:0] == 3'd1 || wr_data[2:0] == 3'd2 || wr_data[2:0] == 3'd4)
                 && (int'(wr_data[2:0]) * NUM_PATHS <= NSEC);
    end

    // Input-valid history and a settle window after regrouping.
    always_ff @(posedge clk) begin
        was_rst <= !rst_n;
        if (!rst_n) begin
            vhist <= '0;
            quiet <= 3'd4;
        end else begin
            vhist <= {vhist[2:0], in_valid};
            if (cnt_wr && good)
                quiet <= 3'd4;
            else if (quiet != 3'd0)
                quiet <= quiet - 3'd1;
        end
    end

    // Check the state on the first edge after reset releases.
    always @(posedge clk) begin
        if (rst_n && was_rst)
            assert_reset_state_R1: assert (!out_valid && !cfg_err && stages == 3'd1);
    end

    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet == 3'd0) |-> (out_valid == vhist[2'(stages - 3'd1)]));

    assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && good) |=> (!cfg_err && !out_valid && stages == $past(wr_data[2:0])));

    assert_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !good) |=> (cfg_err && stages == $past(stages)));

    assert_stages_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> $stable(stages));

    assert_grouping_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stages == 3'd1 || stages == 3'd2 || stages == 3'd4)
        && (int'(stages) * NUM_PATHS <= NSEC));
endmodule

bind biq_bank biq_bank_chk #(.NUM_PATHS(NUM_PATHS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .wr_en     (wr_en),
    .cnt_sel   (wr_addr[7]),
    .wr_data   (wr_data),
    .out_valid (out_valid),
    .cfg_err   (cfg_err),
    .stages    (stages)
);

// File: tb/sim_biq_bank.sv
`timescale 1ns/1ps
// Bench for biq_bank with two paths: a reference model built from the
// requirements, seeded random stimulus and directed corner cases.
module sim_biq_bank;
    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [NP*16-1:0] in_data = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [17:0]   wr_data = '0;
    logic          out_valid;
    logic [NP*16-1:0] out_data;
    logic          cfg_err;

    biq_bank #(.NUM_PATHS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_valid(out_valid), .out_data(out_data), .cfg_err(cfg_err)
    );

    always #2 clk = ~clk;

    int     nchk = 0;
    int     nfail = 0;
    int     n = 0;
    string  tag = "R1";
    int     mS = 1;
    bit     merr = 1'b0;
    int     mc [4][5];
    longint ms1 [4];
    longint ms2 [4];
    bit     ev [8];
    int     ey [8][NP];
    string  et [8];

    task automatic fail(string req, string what, int act, int exp);
        nfail++;
        $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    endtask

    task automatic check(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) fail(req, what, act, exp);
    endtask

    function automatic int rsat(longint v);
        longint r;
        r = (v + 64'sd32768) >>> 16;
        if (r > 32767) return 32767;
        if (r < -32768) return -32768;
        return int'(r);
    endfunction

    function automatic void model_reset();
        mS = 1;
        merr = 1'b0;
        for (int k = 0; k < 4; k++) begin
            mc[k][0] = 65536;
            for (int i = 1; i < 5; i++) mc[k][i] = 0;
            ms1[k] = 0;
            ms2[k] = 0;
        end
    endfunction

    function automatic int run_path(int p, int x);
        int v = x;
        for (int st = 0; st < mS; st++) begin
            int     k = p * mS + st;
            int     y;
            longint acc;
            acc = longint'(mc[k][0]) * v + ms1[k];
            y = rsat(acc);
            ms1[k] = longint'(mc[k][1]) * v + longint'(mc[k][3]) * y + ms2[k];
            ms2[k] = longint'(mc[k][2]) * v + longint'(mc[k][4]) * y;
            v = y;
        end
        return v;
    endfunction

    // One clock: compare the slot due now, then return the inputs to idle.
    task automatic cycle();
        int slot;
        @(negedge clk);
        n++;
        slot = n % 8;
        if (ev[slot] || out_valid) begin
            check((ev[slot] ? et[slot] : "R4"), "out_valid", int'(out_valid), int'(ev[slot]));
            if (ev[slot] && out_valid)
                for (int p = 0; p < NP; p++)
                    check(et[slot], $sformatf("lane%0d", p),
                          int'($signed(out_data[p*16 +: 16])), ey[slot][p]);
        end
        ev[slot] = 1'b0;
        in_valid = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic sample(int x0, int x1);
        int slot;
        cycle();
        slot = (n + mS) % 8;
        in_valid = 1'b1;
        in_data[15:0] = 16'(x0);
        in_data[31:16] = 16'(x1);
        ey[slot][0] = run_path(0, x0);
        ey[slot][1] = run_path(1, x1);
        ev[slot] = 1'b1;
        et[slot] = tag;
    endtask

    task automatic wr(logic [7:0] a, logic [17:0] d);
        cycle();
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        if (a[7]) begin
            int c = int'(d[2:0]);
            if (d[17:3] == 0 && (c == 1 || c == 2 || c == 4) && c * NP <= 4) begin
                mS = c;
                merr = 1'b0;
                for (int k = 0; k < 4; k++) begin ms1[k] = 0; ms2[k] = 0; end
            end else begin
                merr = 1'b1;
            end
        end else begin
            int p = int'(a[6:5]);
            int s = int'(a[4:3]);
            int i = int'(a[2:0]);
            if (p < NP && s < mS && i <= 4) mc[p * mS + s][i] = int'($signed(d));
        end
    endtask

    function automatic logic [7:0] caddr(int p, int s, int i);
        return {1'b0, 2'(p), 2'(s), 3'(i)};
    endfunction

    task automatic flush(int k);
        for (int i = 0; i < k; i++) cycle();
    endtask

    task automatic wr_count(int c, string req);
        flush(6);
        wr(8'h80, 18'(c));
        cycle();
        check(req, "cfg_err", int'(cfg_err), int'(merr));
    endtask

    function automatic int rsmp();
        return int'($urandom_range(0, 65535)) - 32768;
    endfunction

    task automatic rand_coefs();
        for (int p = 0; p < NP; p++)
            for (int s = 0; s < mS; s++)
                for (int i = 0; i < 5; i++) begin
                    int v;
                    if (i < 3) v = int'($urandom_range(1, 262143)) - 131072;
                    else v = int'($urandom_range(0, 65535)) - 32768;
                    wr(caddr(p, s, i), 18'(v));
                end
    endtask

    task automatic rand_run(int cnt, int idle_pct);
        for (int i = 0; i < cnt; i++) begin
            if (int'($urandom_range(0, 99)) < idle_pct) cycle();
            sample(rsmp(), rsmp());
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        #(200000 * 4);
        fail("WDOG", "watchdog expired", 0, 1);
        nchk++;
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        for (int i = 0; i < 8; i++) ev[i] = 1'b0;
        flush(3);
        // R1: outputs held low in reset
        check("R1", "out_valid in reset", int'(out_valid), 0);
        check("R1", "cfg_err in reset", int'(cfg_err), 0);
        @(negedge clk);
        rst_n = 1'b1;
        cycle();
        check("R1", "out_valid after reset", int'(out_valid), 0);
        check("R1", "cfg_err after reset", int'(cfg_err), 0);

        // R9: reset coefficients pass samples through exactly, S=1
        tag = "R9";
        sample(32767, -32768);
        sample(0, 1);
        sample(-1, 12345);
        rand_run(20, 30);

        // R3: half-up rounding ties and both clamp limits on path 0
        tag = "R3";
        wr(caddr(0, 0, 0), 18'(32768));
        sample(1, 7);
        sample(-1, -7);
        sample(3, 100);
        sample(-3, -100);
        wr(caddr(0, 0, 0), 18'(131071));
        sample(32767, 5);
        sample(-32768, -5);
        sample(20000, 0);
        wr(caddr(0, 0, 0), 18'(65536));
        sample(-20000, 1);

        // R6: accepted count of 2, then R4 latency with back-to-back samples
        wr_count(2, "R6");
        tag = "R4";
        sample(111, -222);
        sample(32767, -32768);
        rand_run(20, 0);
        rand_run(20, 50);

        // R7: rejected counts keep S=2
        wr_count(4, "R7");
        wr_count(3, "R7");
        wr_count(0, "R7");
        wr_count(9, "R7");
        tag = "R7";
        rand_run(15, 20);
        wr_count(2, "R6");

        // R2: random coefficients on the full cascade of two paths
        tag = "R2";
        rand_coefs();
        rand_run(400, 30);

        // R8: out-of-range path, stage and index writes are ignored
        wr(caddr(3, 0, 0), 18'(1000));
        wr(caddr(2, 1, 1), 18'(2000));
        wr(caddr(0, 2, 0), 18'(3000));
        wr(caddr(0, 3, 3), 18'(4000));
        wr(caddr(1, 0, 5), 18'(5000));
        wr(caddr(0, 1, 7), 18'(6000));
        tag = "R8";
        rand_run(60, 20);

        // R6: regroup to S=1 while states are live; states must start from zero
        wr_count(1, "R6");
        tag = "R6";
        rand_run(60, 20);

        // R5: new coefficients under the one-stage grouping
        tag = "R5";
        rand_coefs();
        rand_run(120, 10);
        wr(caddr(1, 1, 0), 18'(777));
        rand_run(30, 0);

        flush(8);
        summary();
        $finish;
    end
endmodule